// File: doc/BRIEF.md
# Receive Label Filter and Word Acceptance Gate

This block sits between a serial bus word receiver and its receive FIFO. Each time the receiver presents a complete 32-bit word, the gate decides whether the word is kept. It can check the word's label against a 256-entry enable bit map, compare the two source/destination bits against a configured pair, and test the word for odd parity. A kept word is rearranged into host order and presented with a one-cycle FIFO write strobe.

The enable bit map is maintained by command pulses. One pulse clears every label and another sets every label. Two more clear or set the single label named on an 8-bit address field. A serial loader writes the whole map one bit per cycle, starting from label 0xFF and moving downward. A serial dump port reads the map back in the same descending order. The configuration bits are level inputs. They are normally held static and are driven by a control register outside this block.

Top module: `rx_label_gate`

## Requirements
- R1: After synchronous reset, `fifo_we` and `dump_bit` are 0 and every map entry is cleared. With label filtering on, no word is then accepted.
- R2: The label number of a word is formed with ARINC bit 1 (`word_in[0]`) as its MSB and ARINC bit 8 (`word_in[7]`) as its LSB. When `cfg_label_en`=0, every label passes the filter. When it is 1, a word passes only if the map entry for its label number is 1.
- R3: `cmd_set_one` sets and `cmd_clr_one` clears the map entry addressed by `cmd_label`. If both pulse for the same cycle, the entry ends cleared. A single-entry command takes precedence over a serial load bit in the same cycle.
- R4: `cmd_clr_all` clears all 256 entries and `cmd_set_all` sets them all. Clear-all wins over every other map update in the same cycle.
- R5: On each `load_valid` cycle, `load_bit` is written to the current load address, and the address then moves down by one. `load_start` restarts the address at 0xFF; if `load_valid` is high in the same cycle, that bit goes to 0xFF. For example, the bits 1,0,1,1 set 0xFF, clear 0xFE, and set 0xFD and 0xFC.
- R6: One cycle after `dump_start`, `dump_bit` shows entry 0xFF. Each `dump_next` cycle moves the dump address down by one, and `dump_bit` shows the new entry one cycle later.
- R7: When `cfg_sdi_en`=1, a word is rejected unless `word_in[9]` (ARINC bit 10) equals `cfg_sdi_b10` and `word_in[8]` (ARINC bit 9) equals `cfg_sdi_b9`. When `cfg_sdi_en`=0 these bits are not compared.
- R8: When `cfg_par_chk`=1, the word is still stored whatever its parity. `fifo_data[31]` is 1 if the 32 bits have even parity (an error) and 0 if they have odd parity. When `cfg_par_chk`=0, `fifo_data[31]` carries `word_in[31]` unchanged.
- R9: `fifo_data[30:8]` equals `word_in[30:8]`. That is, host bits 2 to 22 carry ARINC bits 31 down to 11, and host bits 23 and 24 carry ARINC bits 10 and 9.
- R10: The label occupies `fifo_data[7:0]`. When `cfg_label_keep`=0 it is `word_in[7:0]`, which is the bit-reversed label number. When `cfg_label_keep`=1 it is the label number, with ARINC bit 1 in `fifo_data[7]`.
- R11: A map update in the same cycle as `word_valid` does not affect that word's decision. It applies from the next word onward.
- R12: `fifo_we` is a single-cycle pulse, raised exactly one cycle after an accepted `word_valid`. `fifo_data` changes only on accepted words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A complete received word is present |
| word_in | input | 32 | Received word, bit i = ARINC bit i+1 |
| cfg_label_en | input | 1 | Enable label filtering |
| cfg_par_chk | input | 1 | Enable odd parity check and error marker |
| cfg_sdi_en | input | 1 | Enable source/destination bit compare |
| cfg_sdi_b10 | input | 1 | Required value of ARINC bit 10 |
| cfg_sdi_b9 | input | 1 | Required value of ARINC bit 9 |
| cfg_label_keep | input | 1 | Keep the label in received order in the host word |
| cmd_clr_all | input | 1 | Clear all map entries |
| cmd_set_all | input | 1 | Set all map entries |
| cmd_clr_one | input | 1 | Clear the entry at `cmd_label` |
| cmd_set_one | input | 1 | Set the entry at `cmd_label` |
| cmd_label | input | 8 | Address for single-entry commands |
| load_start | input | 1 | Restart serial load at 0xFF |
| load_valid | input | 1 | Serial load bit is valid |
| load_bit | input | 1 | Serial load data |
| dump_start | input | 1 | Restart map readback at 0xFF |
| dump_next | input | 1 | Advance map readback one entry downward |
| dump_bit | output | 1 | Map entry at the readback address |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 32 | Word in host order |

## Verification
A map update and a word lookup can fall in the same cycle. The bench provokes this by pulsing a single-label set and a label clear in the very cycle that a word carrying that label is presented. The first word must follow the map as it stood before the update. A repeat of the same word must then follow the updated map. A second collision puts a clear-all and a set-all in one cycle, and the outcome is judged by a full descending readback followed by a 256-label sweep.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

  typedef struct packed {
    logic label_en;
    logic par_chk;
    logic sdi_en;
    logic sdi_b10;
    logic sdi_b9;
    logic label_keep;
  } rlg_cfg_t;

endpackage

// File: rtl/rlg_bit_rev.sv
module rlg_bit_rev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end

endmodule

// File: rtl/rlg_label_map.sv
module rlg_label_map #(
  parameter int LBL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             set_all,
  input  logic             clr_one,
  input  logic             set_one,
  input  logic [LBL_W-1:0] one_idx,
  input  logic             ld_start,
  input  logic             ld_valid,
  input  logic             ld_bit,
  input  logic             rd_start,
  input  logic             rd_next,
  output logic             rd_bit,
  input  logic [LBL_W-1:0] lk_idx,
  output logic             lk_hit
);

  localparam int DEPTH = 1 << LBL_W;
  localparam logic [LBL_W-1:0] TOP_IDX = {LBL_W{1'b1}};
  localparam logic [LBL_W-1:0] STEP = LBL_W'(1);

  logic [DEPTH-1:0] map_q;
  logic [DEPTH-1:0] map_d;
  logic [LBL_W-1:0] ld_ptr_q;
  logic [LBL_W-1:0] ld_idx;
  logic [LBL_W-1:0] rd_ptr_q;
  logic [LBL_W-1:0] rd_nxt;
  logic             rd_bit_q;

  // serial load address: restart wins over the running pointer
  assign ld_idx = ld_start ? TOP_IDX : ld_ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_ptr_q <= TOP_IDX;
    end else if (ld_valid) begin
      ld_ptr_q <= ld_idx - STEP;
    end else if (ld_start) begin
      ld_ptr_q <= TOP_IDX;
    end
  end

  // update priority: clear-all, set-all, single clear, single set, load
  always_comb begin
    map_d = map_q;
    if (clr_all) begin
      map_d = '0;
    end else if (set_all) begin
      map_d = '1;
    end else begin
      if (ld_valid) map_d[ld_idx] = ld_bit;
      if (set_one)  map_d[one_idx] = 1'b1;
      if (clr_one)  map_d[one_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) map_q <= '0;
    else     map_q <= map_d;
  end

  // lookup sees the map before this cycle's update
  assign lk_hit = map_q[lk_idx];

  // descending readback
  assign rd_nxt = rd_start ? TOP_IDX : (rd_ptr_q - STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr_q <= TOP_IDX;
      rd_bit_q <= 1'b0;
    end else if (rd_start || rd_next) begin
      rd_ptr_q <= rd_nxt;
      rd_bit_q <= map_q[rd_nxt];
    end
  end

  assign rd_bit = rd_bit_q;

endmodule

// File: rtl/rlg_word_check.sv
module rlg_word_check
  import rlg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LBL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rlg_cfg_t          cfg,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic [LBL_W-1:0]  lbl_num,
  input  logic              lbl_hit,
  output logic              fifo_we,
  output logic [WORD_W-1:0] fifo_data
);

  localparam int B9  = LBL_W;
  localparam int B10 = LBL_W + 1;
  localparam int TOP = WORD_W - 1;

  logic              sdi_ok;
  logic              lbl_ok;
  logic              keep;
  logic              top_bit;
  logic [LBL_W-1:0]  lbl_field;
  logic              we_q;
  logic [WORD_W-1:0] data_q;

  assign sdi_ok = !cfg.sdi_en ||
                  ((word_in[B10] == cfg.sdi_b10) && (word_in[B9] == cfg.sdi_b9));
  assign lbl_ok = !cfg.label_en || lbl_hit;
  assign keep   = word_valid && sdi_ok && lbl_ok;

  // even parity over the word marks an error when checking is on
  assign top_bit   = cfg.par_chk ? ~(^word_in) : word_in[TOP];
  assign lbl_field = cfg.label_keep ? lbl_num : word_in[LBL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      data_q <= '0;
    end else begin
      we_q <= keep;
      if (keep) data_q <= {top_bit, word_in[TOP-1:LBL_W], lbl_field};
    end
  end

  assign fifo_we   = we_q;
  assign fifo_data = data_q;

endmodule

// File: rtl/rx_label_gate.sv
module rx_label_gate
  import rlg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LBL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic              cfg_label_en,
  input  logic              cfg_par_chk,
  input  logic              cfg_sdi_en,
  input  logic              cfg_sdi_b10,
  input  logic              cfg_sdi_b9,
  input  logic              cfg_label_keep,
  input  logic              cmd_clr_all,
  input  logic              cmd_set_all,
  input  logic              cmd_clr_one,
  input  logic              cmd_set_one,
  input  logic [LBL_W-1:0]  cmd_label,
  input  logic              load_start,
  input  logic              load_valid,
  input  logic              load_bit,
  input  logic              dump_start,
  input  logic              dump_next,
  output logic              dump_bit,
  output logic              fifo_we,
  output logic [WORD_W-1:0] fifo_data
);

  rlg_cfg_t         cfg;
  logic [LBL_W-1:0] lbl_num;
  logic             lbl_hit;

  assign cfg = '{label_en:   cfg_label_en,
                 par_chk:    cfg_par_chk,
                 sdi_en:     cfg_sdi_en,
                 sdi_b10:    cfg_sdi_b10,
                 sdi_b9:     cfg_sdi_b9,
                 label_keep: cfg_label_keep};

  // first-received label bit becomes the MSB of the label number
  rlg_bit_rev #(.W(LBL_W)) u_rev (
    .din  (word_in[LBL_W-1:0]),
    .dout (lbl_num)
  );

  rlg_label_map #(.LBL_W(LBL_W)) u_map (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (cmd_clr_all),
    .set_all  (cmd_set_all),
    .clr_one  (cmd_clr_one),
    .set_one  (cmd_set_one),
    .one_idx  (cmd_label),
    .ld_start (load_start),
    .ld_valid (load_valid),
    .ld_bit   (load_bit),
    .rd_start (dump_start),
    .rd_next  (dump_next),
    .rd_bit   (dump_bit),
    .lk_idx   (lbl_num),
    .lk_hit   (lbl_hit)
  );

  rlg_word_check #(.WORD_W(WORD_W), .LBL_W(LBL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg        (cfg),
    .word_valid (word_valid),
    .word_in    (word_in),
    .lbl_num    (lbl_num),
    .lbl_hit    (lbl_hit),
    .fifo_we    (fifo_we),
    .fifo_data  (fifo_data)
  );

endmodule

// File: rtl/rlg_checker.sv
module rlg_checker #(
  parameter int WORD_W = 32,
  parameter int LBL_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_in,
  input logic              cfg_label_en,
  input logic              cfg_par_chk,
  input logic              cfg_sdi_en,
  input logic              cfg_sdi_b10,
  input logic              cfg_label_keep,
  input logic              cmd_clr_all,
  input logic              cmd_set_all,
  input logic              fifo_we,
  input logic [WORD_W-1:0] fifo_data
);

  // R12: a write strobe always follows a presented word
  a_r12_we_follows_word: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> $past(word_valid));

  // R2: filter off and compare off means every word is kept
  a_r2_open_filter: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !cfg_label_en && !cfg_sdi_en) |=> fifo_we);

  // R7: a mismatching ARINC bit 10 rejects the word
  a_r7_sdi_reject: assert property (@(posedge clk) disable iff (rst)
    (word_valid && cfg_sdi_en && (word_in[LBL_W+1] != cfg_sdi_b10)) |=> !fifo_we);

  // R8: the top host bit flags an even-parity word
  a_r8_parity_mark: assert property (@(posedge clk) disable iff (rst)
    (word_valid && cfg_par_chk) |=>
      (!fifo_we || (fifo_data[WORD_W-1] == ~(^$past(word_in)))));

  // R9: middle bits pass straight through
  a_r9_body_bits: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> (fifo_data[WORD_W-2:LBL_W] == $past(word_in[WORD_W-2:LBL_W])));

  // R10: with reversal selected the label byte is the raw received byte
  a_r10_label_raw: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !cfg_label_keep) |=>
      (!fifo_we || (fifo_data[LBL_W-1:0] == $past(word_in[LBL_W-1:0]))));

  // R4: after set-all, any label passes when only label filtering is on
  a_r4_set_all_opens: assert property (@(posedge clk) disable iff (rst)
    (cmd_set_all && !cmd_clr_all) ##1 (word_valid && cfg_label_en && !cfg_sdi_en)
      |=> fifo_we);

endmodule

bind rx_label_gate rlg_checker #(.WORD_W(WORD_W), .LBL_W(LBL_W)) u_rlg_checker (
  .clk            (clk),
  .rst            (rst),
  .word_valid     (word_valid),
  .word_in        (word_in),
  .cfg_label_en   (cfg_label_en),
  .cfg_par_chk    (cfg_par_chk),
  .cfg_sdi_en     (cfg_sdi_en),
  .cfg_sdi_b10    (cfg_sdi_b10),
  .cfg_label_keep (cfg_label_keep),
  .cmd_clr_all    (cmd_clr_all),
  .cmd_set_all    (cmd_set_all),
  .fifo_we        (fifo_we),
  .fifo_data      (fifo_data)
);

// File: tb/rx_label_gate_bench.sv
module rx_label_gate_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [31:0] word_in = '0;
  logic        cfg_label_en = 1'b0, cfg_par_chk = 1'b0, cfg_sdi_en = 1'b0;
  logic        cfg_sdi_b10 = 1'b0, cfg_sdi_b9 = 1'b0, cfg_label_keep = 1'b0;
  logic        cmd_clr_all = 1'b0, cmd_set_all = 1'b0;
  logic        cmd_clr_one = 1'b0, cmd_set_one = 1'b0;
  logic [7:0]  cmd_label = '0;
  logic        load_start = 1'b0, load_valid = 1'b0, load_bit = 1'b0;
  logic        dump_start = 1'b0, dump_next = 1'b0;
  logic        dump_bit;
  logic        fifo_we;
  logic [31:0] fifo_data;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  bit  ref_map [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_label_gate u_rx_label_gate (
    .clk, .rst, .word_valid, .word_in,
    .cfg_label_en, .cfg_par_chk, .cfg_sdi_en, .cfg_sdi_b10, .cfg_sdi_b9,
    .cfg_label_keep, .cmd_clr_all, .cmd_set_all, .cmd_clr_one, .cmd_set_one,
    .cmd_label, .load_start, .load_valid, .load_bit, .dump_start, .dump_next,
    .dump_bit, .fifo_we, .fifo_data
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // word whose label number is lbl, with body bits from a hash
  function automatic logic [31:0] mk_word(input int lbl, input int seed);
    logic [23:0] body;
    body = 24'(lbl * 40503 + seed * 9973 + 24'h35A1C7);
    return {body, rev8(8'(lbl))};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one word, then compare the strobe and host word one cycle later
  task automatic send_word(input logic [31:0] w, input string req);
    bit          acc;
    logic [7:0]  lnum;
    logic [31:0] ex;
    lnum = rev8(w[7:0]);
    acc  = (!cfg_label_en || ref_map[lnum]) &&
           (!cfg_sdi_en || (w[9] == cfg_sdi_b10 && w[8] == cfg_sdi_b9));
    ex   = {cfg_par_chk ? ~(^w) : w[31], w[30:8],
            cfg_label_keep ? lnum : w[7:0]};
    word_valid = 1'b1;
    word_in    = w;
    @(negedge clk);
    word_valid = 1'b0;
    check(fifo_we == acc, req, 32'(fifo_we), 32'(acc));
    if (acc) check(fifo_data == ex, req, fifo_data, ex);
  endtask

  task automatic sweep_labels(input int seed, input string req);
    for (int l = 0; l < 256; l++) send_word(mk_word(l, seed), req);
  endtask

  task automatic dump_all(input string req);
    dump_start = 1'b1;
    @(negedge clk);
    dump_start = 1'b0;
    check(dump_bit == ref_map[255], req, 32'(dump_bit), 32'(ref_map[255]));
    dump_next = 1'b1;
    for (int k = 254; k >= 0; k--) begin
      @(negedge clk);
      check(dump_bit == ref_map[k], req, 32'(dump_bit), 32'(ref_map[k]));
    end
    dump_next = 1'b0;
  endtask

  task automatic pulse_cmd(input bit ca, input bit sa, input bit co, input bit so,
                           input logic [7:0] lbl);
    cmd_clr_all = ca; cmd_set_all = sa; cmd_clr_one = co; cmd_set_one = so;
    cmd_label = lbl;
    @(negedge clk);
    cmd_clr_all = 0; cmd_set_all = 0; cmd_clr_one = 0; cmd_set_one = 0;
    if (ca)      foreach (ref_map[i]) ref_map[i] = 1'b0;
    else if (sa) foreach (ref_map[i]) ref_map[i] = 1'b1;
    else if (co) ref_map[lbl] = 1'b0;
    else if (so) ref_map[lbl] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    foreach (ref_map[i]) ref_map[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(fifo_we == 1'b0, "R1", 32'(fifo_we), 0);
    check(dump_bit == 1'b0, "R1", 32'(dump_bit), 0);
    dump_all("R1 R6");
    cfg_label_en = 1'b1;
    sweep_labels(1, "R1 R2");

    // R12: strobe falls after one cycle
    cfg_label_en = 1'b0;
    send_word(mk_word(7, 2), "R12");
    @(negedge clk);
    check(fifo_we == 1'b0, "R12", 32'(fifo_we), 0);

    // R5: leading pattern 1011
    begin
      bit p[4] = '{1, 0, 1, 1};
      for (int k = 0; k < 4; k++) begin
        load_start = (k == 0); load_valid = 1'b1; load_bit = p[k];
        ref_map[255-k] = p[k];
        @(negedge clk);
      end
      load_start = 0; load_valid = 0;
    end
    dump_all("R5");

    // R5 R6 R2: full descending load of a computed pattern, then sweep
    for (int k = 255; k >= 0; k--) begin
      load_start = (k == 255); load_valid = 1'b1;
      load_bit = ((k * 7 + 3) % 5) < 2;
      ref_map[k] = load_bit;
      @(negedge clk);
    end
    load_start = 0; load_valid = 0;
    dump_all("R5 R6");
    cfg_label_en = 1'b1;
    sweep_labels(3, "R2");
    cfg_label_en = 1'b0;
    sweep_labels(4, "R2 R9 R10");

    // R3: single set/clear, and both on one label
    cfg_label_en = 1'b1;
    pulse_cmd(0, 0, 0, 1, 8'h00);
    send_word(mk_word(8'h00, 5), "R3");
    pulse_cmd(0, 0, 1, 0, 8'h00);
    send_word(mk_word(8'h00, 5), "R3");
    pulse_cmd(0, 0, 1, 1, 8'h5A);
    send_word(mk_word(8'h5A, 6), "R3");
    // single command beats a load bit on the same address
    load_start = 1'b1; load_valid = 1'b1; load_bit = 1'b1;
    cmd_clr_one = 1'b1; cmd_label = 8'hFF;
    @(negedge clk);
    load_start = 0; load_valid = 0; cmd_clr_one = 0;
    ref_map[255] = 1'b0;
    send_word(mk_word(8'hFF, 7), "R3");

    // R11: map update in the lookup cycle affects later words only
    ref_map[8'h33] = 1'b0;
    pulse_cmd(0, 0, 1, 0, 8'h33);
    cmd_set_one = 1'b1; cmd_label = 8'h33;
    send_word(mk_word(8'h33, 8), "R11");
    cmd_set_one = 1'b0;
    ref_map[8'h33] = 1'b1;
    send_word(mk_word(8'h33, 8), "R11");
    cmd_clr_one = 1'b1; cmd_label = 8'h33;
    send_word(mk_word(8'h33, 9), "R11");
    cmd_clr_one = 1'b0;
    ref_map[8'h33] = 1'b0;
    send_word(mk_word(8'h33, 9), "R11");

    // R4: global set, then clear-all colliding with set-all
    pulse_cmd(0, 1, 0, 0, 8'h00);
    sweep_labels(10, "R4");
    cmd_set_one = 1'b1; cmd_label = 8'h44;
    pulse_cmd(1, 1, 0, 0, 8'h44);
    dump_all("R4");
    sweep_labels(11, "R4");

    // R7: all compare settings against all bit 10/9 values
    cfg_label_en = 1'b0;
    cfg_sdi_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      cfg_sdi_b10 = c[1]; cfg_sdi_b9 = c[0];
      for (int s = 0; s < 4; s++) begin
        logic [31:0] w = mk_word(s * 13, c);
        w[9] = s[1]; w[8] = s[0];
        send_word(w, "R7");
      end
    end
    cfg_sdi_en = 1'b0;
    begin
      logic [31:0] w = mk_word(3, 3);
      w[9] = ~cfg_sdi_b10;
      send_word(w, "R7");
    end

    // R8 R9 R10: parity marker and host order in every mode
    for (int m = 0; m < 4; m++) begin
      cfg_par_chk = m[0]; cfg_label_keep = m[1];
      for (int l = 0; l < 64; l++) begin
        logic [31:0] w = mk_word(l * 4 + m, l + 20);
        w[31] = l[0];
        send_word(w, "R8 R9 R10");
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule